// File: doc/BRIEF.md
# Wiegand Two-Wire Frame Receiver

This block receives frames from a two-wire Wiegand access-control link. One wire carries the zero bits and the other carries the one bits. Both wires are sampled with the system clock through synchronizer flops. A bit is taken on the edge where a wire goes from its idle level to its active level. Accepted bits are shifted into an accumulator. When no further bit arrives within one bit period and both wires are back at their idle level, the receiver presents the collected frame and its length for one clock and then clears the accumulator.

The wire polarity and the bit period are set by configuration inputs. The following line states are treated as errors: both wires active together, or a wire still active when the bit period ends. An error drops the partial frame and raises a one-clock error strobe. The receiver then ignores the wires until it sees both of them idle at the same time. This keeps miswired or inverted links from being decoded as data.

Top module: `wiegand_rx`

## Requirements
- R1: The active wire level equals `activeHigh`: 0 means the wires are active-low, 1 means active-high. The idle level is the complement of the active level.
- R2: A pulse on `zeroLineIn` alone adds a 0 bit and a pulse on `oneLineIn` alone adds a 1 bit. Exactly one bit is taken per pulse, on its idle-to-active edge.
- R3: At frame end, `frameCount` holds the number of bits. `frameBits` is right-aligned: the first bit received is at index `frameCount-1`, the last at index 0, and all higher bits are 0.
- R4: A frame ends when P clocks pass after the last accepted bit and both wires are idle. `frameValid` then pulses for exactly one clock, no earlier than P and no later than P+4 clocks after the last pulse starts at the pins.
- R5: Both wires active at once, whether idle or in mid-frame, give one single-clock `frameError` pulse. The partial frame is discarded and no `frameValid` follows.
- R6: After an error, every wire change is ignored until both wires are idle together. The next frame then reports only its own bits.
- R7: If a wire is still active when the P-clock timeout ends, `frameError` pulses instead of `frameValid`.
- R8: Bits past `MAX_BITS` (64) are dropped. The frame then reports `frameCount` = 64, `frameOverflow` = 1 and the first 64 bits received.
- R9: While `rst` is high, and right after it is released, `frameValid`, `frameError`, `frameOverflow`, `frameCount` and `frameBits` are all 0.
- R10: The accumulator and the overflow flag clear when a frame is reported. A following frame shows only its own bits and `frameOverflow` = 0.
- R11: P = T << min(`periodSel`, 5) clocks, where T = max(1, `CLK_HZ`/1000). Codes 0 to 5 select 1, 2, 4, 8, 16 and 32 ms; codes 6 and 7 act as 32 ms; code 2 (4 ms) is the usual setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| activeHigh | input | 1 | Wire polarity: 1 active-high, 0 active-low |
| periodSel | input | 3 | Bit period code |
| zeroLineIn | input | 1 | Asynchronous wire carrying 0 bits |
| oneLineIn | input | 1 | Asynchronous wire carrying 1 bits |
| frameValid | output | 1 | One-clock strobe: a frame is ready |
| frameError | output | 1 | One-clock strobe: an illegal line state was detected |
| frameBits | output | MAX_BITS | Bits of the last frame, right-aligned |
| frameCount | output | clog2(MAX_BITS+1) | Bit count of the last frame |
| frameOverflow | output | 1 | The last frame had more than MAX_BITS bits |

## Verification
The assertions check the following on every clock:
- both strobes last one clock and never fire together;
- the error state holds while any wire is active;
- the double-active condition always leads to the error state;
- a reported frame is never empty, and overflow implies a full count;
- the accumulator is empty after each report.

The bench scenarios cover what needs whole pulse sequences: bit order and packing, the timeout latency for several period codes, both polarities, the stuck-wire and double-active errors, the bits ignored while in error, and the overflow cut-off at 64 bits.

// File: rtl/wg_rx_pkg.sv
package wg_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_BAD  = 2'd2
  } rxState_t;

  // Strobes from control to datapath, valid for one clock each.
  typedef struct packed {
    logic shiftEn;   // append one bit
    logic shiftVal;  // value of that bit
    logic clearAcc;  // drop the partial frame
    logic emit;      // publish the frame and clear
  } rxStrobes_t;

endpackage

// File: rtl/wg_line_sync.sv
module wg_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rstVal,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= rstVal;
          else     stage[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= rstVal;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/wg_rx_ctrl.sv
module wg_rx_ctrl
  import wg_rx_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       activeHigh,
  input  logic [2:0] periodSel,
  input  logic [1:0] syncLines,   // [0] zero wire, [1] one wire
  output rxStrobes_t stb,
  output logic       frameError
);

  localparam int TICKS_PER_MS = (CLK_HZ >= 1000) ? (CLK_HZ / 1000) : 1;
  localparam int MAX_TICKS    = TICKS_PER_MS * 32;
  localparam int TMR_W        = $clog2(MAX_TICKS + 1);

  rxState_t         state, nextState;
  logic             act0, act1, prevAct0, prevAct1, rise0, rise1;
  logic [2:0]       shiftAmt;
  logic [TMR_W-1:0] periodTicks, tmr;
  logic             loadTmr, errNext;

  // Level decode against the configured polarity, then edge detect.
  assign act0  = (syncLines[0] == activeHigh);
  assign act1  = (syncLines[1] == activeHigh);
  assign rise0 = act0 && !prevAct0;
  assign rise1 = act1 && !prevAct1;

  assign shiftAmt    = (periodSel > 3'd5) ? 3'd5 : periodSel;
  assign periodTicks = TMR_W'(TICKS_PER_MS) << shiftAmt;

  always_comb begin
    nextState = state;
    stb       = '0;
    loadTmr   = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE, ST_DATA: begin
        if (act0 && act1) begin
          nextState    = ST_BAD;
          stb.clearAcc = 1'b1;
          errNext      = 1'b1;
        end else if (rise0 || rise1) begin
          nextState    = ST_DATA;
          stb.shiftEn  = 1'b1;
          stb.shiftVal = rise1;
          loadTmr      = 1'b1;
        end else if (state == ST_DATA && tmr == '0) begin
          if (!act0 && !act1) begin
            nextState = ST_IDLE;
            stb.emit  = 1'b1;
          end else begin
            nextState    = ST_BAD;
            stb.clearAcc = 1'b1;
            errNext      = 1'b1;
          end
        end
      end
      ST_BAD: begin
        if (!act0 && !act1) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prevAct0   <= 1'b0;
      prevAct1   <= 1'b0;
      tmr        <= '0;
      frameError <= 1'b0;
    end else begin
      state      <= nextState;
      prevAct0   <= act0;
      prevAct1   <= act1;
      frameError <= errNext;
      if (loadTmr)          tmr <= periodTicks - 1'b1;
      else if (tmr != '0)   tmr <= tmr - 1'b1;
    end
  end

  // R6: once in error, stay there while any wire is active.
  assert_bad_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BAD && (act0 || act1)) |=> (state == ST_BAD));

  // R5: double-active always leads to the error state with a strobe.
  assert_both_active_R5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_BAD && act0 && act1) |=> (state == ST_BAD && frameError));

  // R5: error strobe lasts one clock.
  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frameError |=> !frameError);

endmodule

// File: rtl/wg_rx_datapath.sv
module wg_rx_datapath
  import wg_rx_pkg::*;
#(
  parameter int MAX_BITS = 64,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  rxStrobes_t          stb,
  output logic                frameValid,
  output logic [MAX_BITS-1:0] frameBits,
  output logic [CNT_W-1:0]    frameCount,
  output logic                frameOverflow
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_BITS);

  logic [MAX_BITS-1:0] acc;
  logic [CNT_W-1:0]    accCount;
  logic                accOvf;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc           <= '0;
      accCount      <= '0;
      accOvf        <= 1'b0;
      frameValid    <= 1'b0;
      frameBits     <= '0;
      frameCount    <= '0;
      frameOverflow <= 1'b0;
    end else begin
      frameValid <= stb.emit;
      if (stb.emit) begin
        frameBits     <= acc;
        frameCount    <= accCount;
        frameOverflow <= accOvf;
      end
      if (stb.emit || stb.clearAcc) begin
        acc      <= '0;
        accCount <= '0;
        accOvf   <= 1'b0;
      end else if (stb.shiftEn) begin
        if (accCount == FULL) begin
          accOvf <= 1'b1;
        end else begin
          acc      <= {acc[MAX_BITS-2:0], stb.shiftVal};
          accCount <= accCount + 1'b1;
        end
      end
    end
  end

  // R10: reporting a frame leaves an empty accumulator.
  assert_emit_clears_R10: assert property (@(posedge clk) disable iff (rst)
    stb.emit |=> (accCount == '0 && !accOvf));

  // R8: overflow only with a full accumulator.
  assert_ovf_full_R8: assert property (@(posedge clk) disable iff (rst)
    accOvf |-> (accCount == FULL));

  // R3: a reported frame is never empty.
  assert_frame_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    frameValid |-> (frameCount != '0));

  // R4: frame strobe lasts one clock.
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    frameValid |=> !frameValid);

endmodule

// File: rtl/wiegand_rx.sv
module wiegand_rx
  import wg_rx_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int MAX_BITS    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             activeHigh,
  input  logic [2:0]                       periodSel,
  input  logic                             zeroLineIn,
  input  logic                             oneLineIn,
  output logic                             frameValid,
  output logic                             frameError,
  output logic [MAX_BITS-1:0]              frameBits,
  output logic [$clog2(MAX_BITS+1)-1:0]    frameCount,
  output logic                             frameOverflow
);

  localparam int CNT_W = $clog2(MAX_BITS + 1);

  logic [1:0] syncLines;
  rxStrobes_t stb;

  wg_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .rstVal  ({2{~activeHigh}}),
    .asyncIn ({oneLineIn, zeroLineIn}),
    .syncOut (syncLines)
  );

  wg_rx_ctrl #(.CLK_HZ(CLK_HZ)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .activeHigh (activeHigh),
    .periodSel  (periodSel),
    .syncLines  (syncLines),
    .stb        (stb),
    .frameError (frameError)
  );

  wg_rx_datapath #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rst           (rst),
    .stb           (stb),
    .frameValid    (frameValid),
    .frameBits     (frameBits),
    .frameCount    (frameCount),
    .frameOverflow (frameOverflow)
  );

  // R5/R7: a frame and an error are never reported together.
  assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(frameValid && frameError));

endmodule

// File: tb/wiegand_rx_tb_top.sv
module wiegand_rx_tb_top;

  localparam int CLK_HZ = 4000;  // 4 clocks per ms keeps periods short
  localparam int TPM    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        activeHigh = 1'b0;
  logic [2:0]  periodSel = 3'd2;
  logic        zeroLine = 1'b1;
  logic        oneLine = 1'b1;
  logic        frameValid, frameError, frameOverflow;
  logic [63:0] frameBits;
  logic [6:0]  frameCount;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int validSeen = 0;
  int errSeen = 0;
  int lastStart = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (frameValid) validSeen++;
    if (frameError) errSeen++;
  end

  wiegand_rx #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .activeHigh(activeHigh), .periodSel(periodSel),
    .zeroLineIn(zeroLine), .oneLineIn(oneLine),
    .frameValid(frameValid), .frameError(frameError), .frameBits(frameBits),
    .frameCount(frameCount), .frameOverflow(frameOverflow)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int periodOf(input int sel);
    return TPM << ((sel > 5) ? 5 : sel);
  endfunction

  task automatic setLines(input bit a0, input bit a1);
    zeroLine = a0 ? activeHigh : ~activeHigh;
    oneLine  = a1 ? activeHigh : ~activeHigh;
  endtask

  task automatic doReset(input bit ah, input logic [2:0] sel);
    rst = 1'b1;
    activeHigh = ah;
    periodSel = sel;
    setLines(1'b0, 1'b0);
    tick(4);
    rst = 1'b0;
    tick(2);
  endtask

  task automatic sendBit(input bit b);
    setLines(!b, b);
    lastStart = cyc;
    tick(2);
    setLines(1'b0, 1'b0);
    tick(3);
  endtask

  function automatic bit patBit(input int i, input int seed);
    return bit'(((i * 37 + seed) >> 2) & 1);
  endfunction

  task automatic sendPattern(input int n, input int seed,
                             output logic [63:0] expBits, output int expCnt,
                             output bit expOvf);
    expBits = '0; expCnt = 0; expOvf = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit b = patBit(i, seed);
      sendBit(b);
      if (expCnt < 64) begin
        expBits = {expBits[62:0], b};
        expCnt++;
      end else begin
        expOvf = 1'b1;
      end
    end
  endtask

  task automatic waitFrame(input int expCnt, input logic [63:0] expBits,
                           input bit expOvf, input int p, input string req);
    bit got = 1'b0;
    int lat = 0;
    int e0 = errSeen;
    for (int i = 0; i < p + 20 && !got; i++) begin
      tick();
      if (frameValid) begin
        got = 1'b1;
        lat = cyc - lastStart;
      end
    end
    check(got, req, "frameValid seen", 64'(got), 64'd1);
    check(errSeen == e0, req, "no error during frame", 64'(errSeen - e0), 64'd0);
    if (got) begin
      check(lat >= p && lat <= p + 4, "R4", "frame latency", 64'(lat), 64'(p + 3));
      check(frameCount == 7'(expCnt), "R3", "frameCount", 64'(frameCount), 64'(expCnt));
      check(frameBits == expBits, "R3", "frameBits", frameBits, expBits);
      check(frameOverflow == expOvf, "R8", "frameOverflow", 64'(frameOverflow), 64'(expOvf));
      tick();
      check(!frameValid, "R4", "strobe single clock", 64'(frameValid), 64'd0);
    end
  endtask

  // R9: reset state
  task automatic testReset();
    doReset(1'b0, 3'd2);
    check(!frameValid, "R9", "frameValid after reset", 64'(frameValid), 64'd0);
    check(!frameError, "R9", "frameError after reset", 64'(frameError), 64'd0);
    check(!frameOverflow, "R9", "frameOverflow after reset", 64'(frameOverflow), 64'd0);
    check(frameCount == '0, "R9", "frameCount after reset", 64'(frameCount), 64'd0);
    check(frameBits == '0, "R9", "frameBits after reset", frameBits, 64'd0);
  endtask

  // R1 R2 R3 R4: active-low 26-bit frame, 4 ms period
  task automatic testActiveLow();
    logic [63:0] eb; int ec; bit eo;
    doReset(1'b0, 3'd2);
    sendPattern(26, 5, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(2), "R2");
  endtask

  // R1 R11: active-high frame, period code 1
  task automatic testActiveHigh();
    logic [63:0] eb; int ec; bit eo;
    doReset(1'b1, 3'd1);
    sendPattern(5, 11, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(1), "R1");
  endtask

  // R11: shortest and clamped period codes
  task automatic testPeriods();
    doReset(1'b0, 3'd0);
    sendBit(1'b0);
    waitFrame(1, 64'd0, 1'b0, periodOf(0), "R11");
    doReset(1'b0, 3'd7);
    sendBit(1'b1);
    waitFrame(1, 64'd1, 1'b0, periodOf(7), "R11");
  endtask

  // R5 R6 R10: double-active mid-frame, pulses ignored while in error
  task automatic testBothActive();
    logic [63:0] eb; int ec; bit eo;
    int v0, e0;
    doReset(1'b0, 3'd2);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    v0 = validSeen; e0 = errSeen;
    setLines(1'b1, 1'b1);
    tick(8);
    check(errSeen - e0 == 1, "R5", "one error strobe", 64'(errSeen - e0), 64'd1);
    // keep the one wire active, pulse the zero wire
    for (int k = 0; k < 3; k++) begin
      setLines(1'b0, 1'b1); tick(2);
      setLines(1'b1, 1'b1); tick(2);
    end
    setLines(1'b0, 1'b1);
    tick(periodOf(2) + 10);
    check(validSeen == v0, "R6", "no frame while in error", 64'(validSeen - v0), 64'd0);
    check(errSeen - e0 == 1, "R6", "no extra error", 64'(errSeen - e0), 64'd1);
    setLines(1'b0, 1'b0);
    tick(4);
    sendPattern(4, 3, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(2), "R6");
    check(validSeen - v0 == 1, "R5", "discarded frame never reported", 64'(validSeen - v0), 64'd1);
  endtask

  // R7: stuck wire past the timeout
  task automatic testStuck();
    logic [63:0] eb; int ec; bit eo;
    int v0, e0;
    doReset(1'b0, 3'd2);
    v0 = validSeen; e0 = errSeen;
    sendBit(1'b1);
    setLines(1'b1, 1'b0);
    tick(periodOf(2) * 3);
    check(errSeen - e0 == 1, "R7", "error on stuck wire", 64'(errSeen - e0), 64'd1);
    check(validSeen == v0, "R7", "no frame on stuck wire", 64'(validSeen - v0), 64'd0);
    setLines(1'b0, 1'b0);
    tick(4);
    sendPattern(3, 9, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(2), "R7");
  endtask

  // R8 R10: overflow, then a clean frame
  task automatic testOverflow();
    logic [63:0] eb; int ec; bit eo;
    doReset(1'b0, 3'd2);
    sendPattern(70, 1, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(2), "R8");
    check(frameCount == 7'd64, "R8", "count capped", 64'(frameCount), 64'd64);
    check(frameOverflow, "R8", "overflow flagged", 64'(frameOverflow), 64'd1);
    tick(5);
    sendPattern(7, 2, eb, ec, eo);
    waitFrame(ec, eb, eo, periodOf(2), "R10");
  endtask

  initial begin
    testReset();
    testActiveLow();
    testActiveHigh();
    testPeriods();
    testBothActive();
    testStuck();
    testOverflow();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 100_000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule